// File: doc/BRIEF.md
# Banked GPIO Controller with Relocatable Index/Data Ports

The controller owns 22 general-purpose pins split into three banks: bank 1 holds pins 10-17, bank 2 holds pins 20-25 and bank 3 holds pins 30-37. Each pin has a configuration byte in a separate configuration space. That byte chooses the direction, an optional polarity inversion, and whether the pad is handed to an alternate peripheral function. Pins 20-24 have no alternate peripheral in the surrounding chip, but they keep the same configuration format.

Pin data is not memory-mapped directly. Software uses an I/O port pair instead: it writes a bank number to the index port, then reads or writes that bank's data through the data port. A select register in configuration space turns the pair on and moves it to one of four address pairs. A small state machine holds the selected bank. Its states are `IDX_NONE`, `IDX_BANK1`, `IDX_BANK2` and `IDX_BANK3`.

The state machine has these transitions:
- Reset enters `IDX_NONE`.
- A write of 1, 2 or 3 to the index port moves to `IDX_BANK1`, `IDX_BANK2` or `IDX_BANK3`.
- A write of any other value to the index port returns to `IDX_NONE`.
- Every other cycle holds the current state.

Top module: `gpx_ctrl`

## Requirements
- R1: After reset every pin is a non-inverted GPIO input. `pin_oe` is all zero, every pin configuration byte reads 0x01, and the select register reads 0x00.
- R2: The select register lives at configuration address 0x03.
  - Bit 7 enables the port pair.
  - Bits 1:0 pick the index/data addresses: 0 gives 0xE0/0xE1, 1 gives 0xE2/0xE3, 2 gives 0xE4/0xE5, and 3 gives 0xEA/0xEB.
  - Bits 6:2 read as 0.
- R3: `io_hit` is high only while the pair is enabled and a read or write targets its index or data address.
  - When the pair is disabled, accesses are not claimed and `io_rdata` is 0.
  - A disabled-pair access leaves the index state and the data latches unchanged.
- R4: Writing 0x01, 0x02 or 0x03 to the index port selects bank 1, 2 or 3.
  - Any other value deselects all banks.
  - While no bank is selected, data reads return 0 and data writes have no effect.
- R5: Bit n of a bank's data register maps to pin bank*10+n. A data write appears on `pin_out` of non-inverted GPIO output pins one clock later.
- R6: In bank 2, data bits 7:6 are not stored and read as 0.
- R7: Each pin configuration byte uses bit 0 for direction (1 = input), bit 1 for inversion and bit 3 for alternate function. The other bits read as 0.
  - Pins 10-17 are at 0xE0-0xE7.
  - Pins 20-25 are at 0xE8-0xED.
  - Pins 30-37 are at 0xF5-0xFC.
- R8: For an inverted GPIO pin, the output drives the complement of its latch bit, and a read of an input pin returns the complement of its sampled level.
- R9: A data read returns the output latch bit, uninverted, for GPIO output pins. For GPIO input pins it returns the sampled level after inversion.
- R10: A pin in alternate mode takes `pin_oe` and `pin_out` from `alt_oe` and `alt_out`. Its data latch is ignored, and a data read returns its sampled level without inversion.
- R11: Pin inputs pass through one sampling register, so a level change is seen by data reads one clock later.
- R12: A read of the index port returns the selected bank number, or 0 in `IDX_NONE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration-space write strobe |
| cfg_addr | input | 8 | Configuration-space address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational on `cfg_addr`) |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not claimed |
| io_hit | output | 1 | Access claimed by the port pair |
| pin_in | input | 22 | Pad input levels, flat order: pins 10-17, 20-25, 30-37 |
| pin_out | output | 22 | Pad output values |
| pin_oe | output | 22 | Pad output enables |
| alt_out | input | 22 | Alternate function output values |
| alt_oe | input | 22 | Alternate function output enables |

## Verification
Each bank gets distinct data patterns so that a swapped bank, a shifted bit or a wrong bank width shows on `pin_out`. An all-ones write to bank 2 exposes its two unstored bits.

Index values 1, 2, 3 and an out-of-range value separate correct bank selection from a decoder that falls through to a default bank. Accesses made while the pair is disabled, and accesses at a pair address that is not selected, test the address claim, and a later readback shows that the latches were kept.

Inverted, alternate-mode and plain pins are mixed within one bank, so a mux that applies inversion in the wrong mode disagrees with the expected pin levels and readback.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int B1_W   = 8;
    localparam int B2_W   = 6;
    localparam int B3_W   = 8;
    localparam int NPIN   = B1_W + B2_W + B3_W;
    localparam int B2_OFS = B1_W;
    localparam int B3_OFS = B1_W + B2_W;

    localparam logic [7:0] B1_CFG_BASE = 8'hE0;
    localparam logic [7:0] B2_CFG_BASE = 8'hE8;
    localparam logic [7:0] B3_CFG_BASE = 8'hF5;

    typedef enum logic [1:0] {
        IDX_NONE  = 2'd0,
        IDX_BANK1 = 2'd1,
        IDX_BANK2 = 2'd2,
        IDX_BANK3 = 2'd3
    } idx_state_e;

    // configuration-space address of flat pin p
    function automatic logic [7:0] cfg_addr_of(input int p);
        if (p < B2_OFS)
            return 8'(int'(B1_CFG_BASE) + p);
        else if (p < B3_OFS)
            return 8'(int'(B2_CFG_BASE) + p - B2_OFS);
        else
            return 8'(int'(B3_CFG_BASE) + p - B3_OFS);
    endfunction

    // index port address for a pair selection; data port is the next one
    function automatic logic [7:0] pair_base(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'hE0;
            2'd1:    return 8'hE2;
            2'd2:    return 8'hE4;
            default: return 8'hEA;
        endcase
    endfunction

endpackage

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
    import gpx_pkg::*;
#(
    parameter logic [7:0] SEL_ADDR = 8'h03
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [7:0]      cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    output logic            port_en,
    output logic [1:0]      pair_sel,
    output logic [NPIN-1:0] dir_in,
    output logic [NPIN-1:0] inv,
    output logic [NPIN-1:0] alt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en  <= 1'b0;
            pair_sel <= 2'd0;
        end else if (cfg_wr && cfg_addr == SEL_ADDR) begin
            port_en  <= cfg_wdata[7];
            pair_sel <= cfg_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_in <= '1;
            inv    <= '0;
            alt    <= '0;
        end else if (cfg_wr) begin
            for (int p = 0; p < NPIN; p++) begin
                if (cfg_addr == cfg_addr_of(p)) begin
                    dir_in[p] <= cfg_wdata[0];
                    inv[p]    <= cfg_wdata[1];
                    alt[p]    <= cfg_wdata[3];
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (cfg_addr == SEL_ADDR)
            cfg_rdata = {port_en, 5'b0, pair_sel};
        for (int p = 0; p < NPIN; p++) begin
            if (cfg_addr == cfg_addr_of(p))
                cfg_rdata = {4'b0, alt[p], 1'b0, inv[p], dir_in[p]};
        end
    end

endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_en,
    input  logic [1:0]      pair_sel,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_addr,
    input  logic [7:0]      io_wdata,
    input  logic [NPIN-1:0] dir_in,
    input  logic [NPIN-1:0] inv,
    input  logic [NPIN-1:0] alt,
    input  logic [NPIN-1:0] pin_smp,
    output logic            io_hit,
    output logic [7:0]      io_rdata,
    output logic            idx_rd,
    output logic [NPIN-1:0] latch
);

    idx_state_e      st, st_nx;
    logic [7:0]      base;
    logic            hit_idx, hit_dat;
    logic [NPIN-1:0] view;

    assign base    = pair_base(pair_sel);
    assign hit_idx = port_en && (io_addr == base);
    assign hit_dat = port_en && (io_addr == 8'(base + 8'd1));
    assign io_hit  = (io_rd || io_wr) && (hit_idx || hit_dat);
    assign idx_rd  = io_rd && hit_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= IDX_NONE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (io_wr && hit_idx) begin
            unique case (io_wdata)
                8'h01:   st_nx = IDX_BANK1;
                8'h02:   st_nx = IDX_BANK2;
                8'h03:   st_nx = IDX_BANK3;
                default: st_nx = IDX_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
        end else if (io_wr && hit_dat) begin
            unique case (st)
                IDX_BANK1: latch[0 +: B1_W]      <= io_wdata[B1_W-1:0];
                IDX_BANK2: latch[B2_OFS +: B2_W] <= io_wdata[B2_W-1:0];
                IDX_BANK3: latch[B3_OFS +: B3_W] <= io_wdata[B3_W-1:0];
                IDX_NONE:  ;
            endcase
        end
    end

    // per-pin readback value
    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_view
            assign view[p] = alt[p]    ? pin_smp[p] :
                             dir_in[p] ? (pin_smp[p] ^ inv[p]) : latch[p];
        end
    endgenerate

    // outputs
    always_comb begin
        io_rdata = 8'h00;
        if (idx_rd) begin
            io_rdata = {6'b0, st};
        end else if (io_rd && hit_dat) begin
            unique case (st)
                IDX_BANK1: io_rdata = 8'(view[0 +: B1_W]);
                IDX_BANK2: io_rdata = 8'(view[B2_OFS +: B2_W]);
                IDX_BANK3: io_rdata = 8'(view[B3_OFS +: B3_W]);
                IDX_NONE:  io_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/gpx_pin_mux.sv
module gpx_pin_mux
    import gpx_pkg::*;
(
    input  logic [NPIN-1:0] dir_in,
    input  logic [NPIN-1:0] inv,
    input  logic [NPIN-1:0] alt,
    input  logic [NPIN-1:0] latch,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            assign pin_oe[p]  = alt[p] ? alt_oe[p]  : !dir_in[p];
            assign pin_out[p] = alt[p] ? alt_out[p] : (latch[p] ^ inv[p]);
        end
    endgenerate

endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter logic [7:0] SEL_ADDR = 8'h03
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [7:0]      cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_addr,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    output logic            io_hit,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe
);

    logic            port_en;
    logic [1:0]      pair_sel;
    logic [NPIN-1:0] dir_in, inv, alt_mode, latch, pin_smp;
    logic            idx_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) pin_smp <= '0;
        else        pin_smp <= pin_in;
    end

    gpx_cfg_regs #(.SEL_ADDR(SEL_ADDR)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .port_en(port_en),
        .pair_sel(pair_sel), .dir_in(dir_in), .inv(inv), .alt(alt_mode)
    );

    gpx_port u_port (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .pair_sel(pair_sel),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .dir_in(dir_in), .inv(inv), .alt(alt_mode), .pin_smp(pin_smp),
        .io_hit(io_hit), .io_rdata(io_rdata), .idx_rd(idx_rd), .latch(latch)
    );

    gpx_pin_mux u_mux (
        .dir_in(dir_in), .inv(inv), .alt(alt_mode), .latch(latch),
        .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
    );

endmodule

// File: rtl/gpx_ctrl_chk.sv
module gpx_ctrl_chk
    import gpx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic            io_wr,
    input logic            io_hit,
    input logic [7:0]      io_rdata,
    input logic            port_en,
    input logic            idx_rd,
    input logic [NPIN-1:0] alt_mode,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] alt_out,
    input logic [NPIN-1:0] alt_oe
);

    a_r3_no_claim_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !io_hit);

    a_r3_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> io_rdata == 8'h00);

    a_r12_index_code: assert property (@(posedge clk) disable iff (!rst_n)
        idx_rd |-> io_rdata[7:2] == 6'd0);

    a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(io_wr) && !$past(cfg_wr)) |-> $stable(pin_out & ~alt_mode));

    a_r10_alt_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & alt_mode) == (alt_oe & alt_mode)) &&
        ((pin_out & alt_mode) == (alt_out & alt_mode)));

endmodule

bind gpx_ctrl gpx_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .io_wr(io_wr),
    .io_hit(io_hit), .io_rdata(io_rdata), .port_en(port_en), .idx_rd(idx_rd),
    .alt_mode(alt_mode), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe)
);

// File: tb/gpx_ctrl_tb.sv
module gpx_ctrl_tb;

    localparam int NP = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
    logic          io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]    io_addr = 8'h00, io_wdata = 8'h00, io_rdata;
    logic          io_hit;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_wr(io_wr),
        .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d, output logic h);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata; h = io_hit;
        #1 io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        chk("R1 pin_oe after reset", pin_oe, '0);
        cfg_read(8'hE0, d); chk("R1 cfg pin10", d, 8'h01);
        cfg_read(8'hED, d); chk("R1 cfg pin25", d, 8'h01);
        cfg_read(8'hFC, d); chk("R1 cfg pin37", d, 8'h01);
        cfg_read(8'h03, d); chk("R1 select reg", d, 8'h00);
    endtask

    task automatic t_pairs();
        logic [7:0] d; logic h;
        cfg_write(8'h03, 8'hFF);
        cfg_read(8'h03, d); chk("R2 select readback", d, 8'h83);
        io_read(8'hEA, d, h); chk("R2 pair3 index hit", h, 1'b1);
        io_read(8'hEB, d, h); chk("R2 pair3 data hit", h, 1'b1);
        io_read(8'hE0, d, h); chk("R2 pair0 not hit", h, 1'b0);
        cfg_write(8'h03, 8'h81);
        io_read(8'hE2, d, h); chk("R2 pair1 index hit", h, 1'b1);
        io_read(8'hEA, d, h); chk("R2 pair3 released", h, 1'b0);
        cfg_write(8'h03, 8'h82);
        io_read(8'hE5, d, h); chk("R2 pair2 data hit", h, 1'b1);
        cfg_write(8'h03, 8'h80);
        io_read(8'hE1, d, h); chk("R2 pair0 data hit", h, 1'b1);
    endtask

    task automatic t_disabled();
        logic [7:0] d; logic h;
        cfg_write(8'h03, 8'h80);
        io_write(8'hE0, 8'h01);
        io_write(8'hE1, 8'h00);
        cfg_write(8'h03, 8'h00);
        io_write(8'hE1, 8'hFF);
        io_write(8'hE0, 8'h03);
        io_read(8'hE1, d, h);
        chk("R3 no claim when off", h, 1'b0);
        chk("R3 rdata zero when off", d, 8'h00);
        cfg_write(8'h03, 8'h80);
        io_read(8'hE0, d, h); chk("R3 index kept", d, 8'h01);
        for (int p = 0; p < 8; p++) cfg_write(8'hE0 + 8'(p), 8'h00);
        @(negedge clk);
        chk("R3 latch kept", pin_out[7:0], 8'h00);
    endtask

    task automatic t_bank_map();
        logic [7:0] d; logic h;
        for (int p = 0; p < 6; p++) cfg_write(8'hE8 + 8'(p), 8'h00);
        for (int p = 0; p < 8; p++) cfg_write(8'hF5 + 8'(p), 8'h00);
        cfg_write(8'h03, 8'h83);
        @(negedge clk); chk("R7 all outputs", pin_oe, {NP{1'b1}});
        io_write(8'hEA, 8'h01); io_write(8'hEB, 8'hA5);
        chk("R5 bank1 pins", pin_out[7:0], 8'hA5);
        io_write(8'hEA, 8'h02); io_write(8'hEB, 8'hFF);
        chk("R5 bank2 pins", pin_out[13:8], 6'h3F);
        io_read(8'hEB, d, h); chk("R6 bank2 top bits", d, 8'h3F);
        io_write(8'hEA, 8'h03); io_write(8'hEB, 8'h3C);
        chk("R5 bank3 pins", pin_out[21:14], 8'h3C);
        chk("R5 pin25", pin_out[13], 1'b1);
        io_read(8'hEB, d, h); chk("R9 output readback", d, 8'h3C);
    endtask

    task automatic t_index();
        logic [7:0] d; logic h;
        io_write(8'hEA, 8'h02);
        io_read(8'hEA, d, h); chk("R12 index readback", d, 8'h02);
        io_write(8'hEA, 8'h07);
        io_read(8'hEA, d, h); chk("R4 bad index deselects", d, 8'h00);
        io_read(8'hEB, d, h); chk("R4 no-bank read", d, 8'h00);
        io_write(8'hEB, 8'h00);
        chk("R4 no-bank write ignored", pin_out, {8'h3C, 6'h3F, 8'hA5});
    endtask

    task automatic t_polarity();
        logic [7:0] d; logic h;
        cfg_write(8'hE1, 8'h02);
        chk("R8 inverted output", pin_out[1], 1'b1);
        cfg_write(8'hF5, 8'h03);
        io_write(8'hEA, 8'h03);
        io_read(8'hEB, d, h); chk("R8 inverted input low", d[0], 1'b1);
        @(negedge clk); pin_in[14] = 1'b1; io_addr = 8'hEB; io_rd = 1'b1;
        #1 chk("R11 before sample", io_rdata[0], 1'b1);
        io_rd = 1'b0;
        io_read(8'hEB, d, h); chk("R11 after sample", d[0], 1'b0);
        chk("R9 bank3 others latch", d[7:1], 7'h1E);
    endtask

    task automatic t_alt();
        logic [7:0] d; logic h;
        alt_oe[2] = 1'b1; alt_out[2] = 1'b0;
        cfg_write(8'hE2, 8'h0A);
        chk("R10 alt value", pin_out[2], 1'b0);
        alt_oe[2] = 1'b0; #1;
        chk("R10 alt enable", pin_oe[2], 1'b0);
        io_write(8'hEA, 8'h01); io_write(8'hEB, 8'hFF);
        alt_out[2] = 1'b1; #1;
        chk("R10 latch ignored", pin_out[2], 1'b1);
        pin_in[2] = 1'b1;
        @(negedge clk);
        io_read(8'hEB, d, h); chk("R10 alt read uninverted", d[2], 1'b1);
        alt_out[2] = 1'b0; #1;
        chk("R10 alt follows", pin_out[2], 1'b0);
    endtask

    task automatic t_cfg_fields();
        logic [7:0] d;
        cfg_write(8'hE8, 8'hFF);
        cfg_read(8'hE8, d); chk("R7 field mask", d, 8'h0B);
        cfg_write(8'hE8, 8'hF4);
        cfg_read(8'hE8, d); chk("R7 other bits", d, 8'h00);
        @(negedge clk); chk("R7 pin20 output", pin_oe[8], 1'b1);
    endtask

    initial begin
        #4ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pairs();
        t_disabled();
        t_bank_map();
        t_index();
        t_polarity();
        t_alt();
        t_cfg_fields();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule